// File: doc/BRIEF.md
# Operand Register Selector

This block turns the generic "source" and "destination" operand references used by microcode into concrete register codes for the register file. It keeps two hidden 5-bit selectors. The first (M) names the register field of the instruction. The second (N) names the register/memory field. Each selector is loaded from the field of the instruction byte that the instruction form calls for. A swap stage on the outputs applies the instruction's direction bit, so microcode always asks for "source" and "destination" and never has to know the operand order.

The instruction byte stream arrives on one 8-bit port with two strobes. One strobe marks the first (opcode) byte and the other marks the second (mod-reg-r/m) byte. The decoder beside this block flags the instruction form with three qualifiers: accumulator-immediate, register-in-opcode and segment-register move. Selector contents and the applied direction change only on the edge that completes a load, and hold at all other times.

Top module: `operand_selector`

## Requirements
- R1: While reset is asserted (asynchronously, active low), and for the synchronizer cycles after its release, both outputs read 5'h00.
- R2: Every output code is {class[4], width[3], index[2:0]}: class 0 is a general register and class 1 a segment register; width 1 selects the 16-bit register and width 0 the 8-bit register.
- R3: A first-byte strobe with `acc_form` high loads both selectors with the accumulator code {0, ibyte[0], 3'b000} and direction 0, whatever the other byte bits and qualifiers hold.
- R4: A first-byte strobe with `use_opreg` high and `acc_form` low loads both selectors with {0, ibyte[3], ibyte[2:0]} and direction 0.
- R5: A first-byte strobe with neither qualifier arms a pending load that records width = ibyte[0] and direction = ibyte[1]. The next second-byte strobe then loads M = {0, width, ibyte[5:3]} and N = {0, width, ibyte[2:0]}.
- R6: With direction 0, `src_code` shows M and `dst_code` shows N. With direction 1, the two are exchanged.
- R7: When `seg_form` is high on an arming first-byte strobe, width is forced to 1 and the second-byte strobe loads M = {1, 1, 0, ibyte[4:3]}, while N is still the 16-bit general register named by ibyte[2:0].
- R8: A second-byte strobe with no pending load has no effect on the outputs. A pending load is used up by its second-byte strobe.
- R9: Without a completing load the outputs hold. An arming first-byte strobe alone does not change them.
- R10: If both strobes are high on the same edge, the first-byte strobe is acted on, the second-byte strobe is ignored, and any pending load is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_first | input | 1 | First (opcode) byte strobe |
| ld_second | input | 1 | Second (mod-reg-r/m) byte strobe |
| ibyte | input | 8 | Instruction byte currently presented |
| acc_form | input | 1 | Instruction is the accumulator-immediate form (with ld_first) |
| use_opreg | input | 1 | Register number sits in the opcode byte (with ld_first) |
| seg_form | input | 1 | Register field names a segment register (with ld_first) |
| src_code | output | 5 | Concrete source register code |
| dst_code | output | 5 | Concrete destination register code |

## Verification
Two functions can fall in the same cycle: a new instruction's first byte and a pending mod-reg-r/m load. Both strobes can be high on one edge. The bench arms a pending load, then raises both strobes together with a register-in-opcode byte. It checks that the opcode register reaches both outputs, and that a later lone second-byte strobe changes nothing, which shows the pending load was cleared. A second overlap is a selector reload together with a change of direction. Each table vector changes the direction and the selector contents on one edge, and the bench judges the swapped outputs in the cycle after that edge.

// File: rtl/opsel_pkg.sv
package opsel_pkg;
  parameter int IDX_W  = 3;
  parameter int BYTE_W = 8;
  localparam int CODE_W = IDX_W + 2;
  localparam int WIDE_POS = IDX_W;
  localparam int CLASS_POS = IDX_W + 1;
  localparam int SEG_W = 2;

  // field positions in the instruction bytes
  localparam int OPC_WIDE_BIT = 0;
  localparam int OPC_DIR_BIT  = 1;
  localparam int OPR_WIDE_BIT = 3;
  localparam int OPR_IDX_LSB  = 0;
  localparam int REG_LSB      = 3;
  localparam int RM_LSB       = 0;
  localparam int SEG_LSB      = 3;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic  load;
    code_t m;
    code_t n;
    logic  dir;
  } sel_upd_t;

  typedef struct packed {
    logic armed;
    logic wide;
    logic dir;
    logic seg;
  } pend_t;

  function automatic code_t make_code(logic cls, logic wide, logic [IDX_W-1:0] idx);
    return {cls, wide, idx};
  endfunction
endpackage

// File: rtl/opsel_rst_sync.sv
module opsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/opsel_decode.sv
module opsel_decode
  import opsel_pkg::*;
(
  input  logic              ld_first,
  input  logic              ld_second,
  input  logic [BYTE_W-1:0] ibyte,
  input  logic              acc_form,
  input  logic              use_opreg,
  input  logic              seg_form,
  input  pend_t             pend_q,
  output pend_t             pend_nxt,
  output sel_upd_t          upd
);
  logic [IDX_W-1:0] seg_idx;

  always_comb begin
    seg_idx = '0;
    seg_idx[SEG_W-1:0] = ibyte[SEG_LSB +: SEG_W];
  end

  always_comb begin
    pend_nxt = pend_q;
    upd      = '0;
    if (ld_first) begin
      pend_nxt.armed = 1'b0;
      if (acc_form) begin
        upd.load = 1'b1;
        upd.m    = make_code(1'b0, ibyte[OPC_WIDE_BIT], '0);
        upd.n    = upd.m;
        upd.dir  = 1'b0;
      end else if (use_opreg) begin
        upd.load = 1'b1;
        upd.m    = make_code(1'b0, ibyte[OPR_WIDE_BIT], ibyte[OPR_IDX_LSB +: IDX_W]);
        upd.n    = upd.m;
        upd.dir  = 1'b0;
      end else begin
        pend_nxt.armed = 1'b1;
        pend_nxt.wide  = ibyte[OPC_WIDE_BIT] | seg_form;
        pend_nxt.dir   = ibyte[OPC_DIR_BIT];
        pend_nxt.seg   = seg_form;
      end
    end else if (ld_second && pend_q.armed) begin
      pend_nxt.armed = 1'b0;
      upd.load = 1'b1;
      upd.dir  = pend_q.dir;
      upd.n    = make_code(1'b0, pend_q.wide, ibyte[RM_LSB +: IDX_W]);
      if (pend_q.seg) upd.m = make_code(1'b1, 1'b1, seg_idx);
      else            upd.m = make_code(1'b0, pend_q.wide, ibyte[REG_LSB +: IDX_W]);
    end
  end
endmodule

// File: rtl/opsel_regs.sv
module opsel_regs
  import opsel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_q_n,
  input  sel_upd_t upd,
  input  pend_t    pend_nxt,
  output pend_t    pend_q,
  output code_t    m_q,
  output code_t    n_q,
  output logic     dir_q
);
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pend_q <= '0;
      m_q    <= '0;
      n_q    <= '0;
      dir_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      if (upd.load) begin
        m_q   <= upd.m;
        n_q   <= upd.n;
        dir_q <= upd.dir;
      end
    end
  end
endmodule

// File: rtl/opsel_swap.sv
module opsel_swap #(
  parameter int W = 5
) (
  input  logic [W-1:0] m_in,
  input  logic [W-1:0] n_in,
  input  logic         dir,
  output logic [W-1:0] src,
  output logic [W-1:0] dst
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    assign src[i] = dir ? n_in[i] : m_in[i];
    assign dst[i] = dir ? m_in[i] : n_in[i];
  end
endmodule

// File: rtl/operand_selector.sv
module operand_selector
  import opsel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_first,
  input  logic              ld_second,
  input  logic [BYTE_W-1:0] ibyte,
  input  logic              acc_form,
  input  logic              use_opreg,
  input  logic              seg_form,
  output logic [CODE_W-1:0] src_code,
  output logic [CODE_W-1:0] dst_code
);
  logic     rst_q_n;
  pend_t    pend_q;
  pend_t    pend_nxt;
  sel_upd_t upd;
  code_t    m_q;
  code_t    n_q;
  logic     dir_q;

  opsel_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  opsel_decode u_dec (
    .ld_first(ld_first), .ld_second(ld_second), .ibyte(ibyte),
    .acc_form(acc_form), .use_opreg(use_opreg), .seg_form(seg_form),
    .pend_q(pend_q), .pend_nxt(pend_nxt), .upd(upd)
  );

  opsel_regs u_regs (
    .clk(clk), .rst_q_n(rst_q_n), .upd(upd), .pend_nxt(pend_nxt),
    .pend_q(pend_q), .m_q(m_q), .n_q(n_q), .dir_q(dir_q)
  );

  opsel_swap #(.W(CODE_W)) u_swap (
    .m_in(m_q), .n_in(n_q), .dir(dir_q), .src(src_code), .dst(dst_code)
  );
endmodule

// File: rtl/operand_selector_chk.sv
module operand_selector_chk
  import opsel_pkg::*;
(
  input logic              clk,
  input logic              rst_q_n,
  input logic              ld_first,
  input logic              ld_second,
  input logic              acc_form,
  input logic              use_opreg,
  input logic [CODE_W-1:0] src_code,
  input logic [CODE_W-1:0] dst_code
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_q_n |-> (src_code == '0 && dst_code == '0));

  a_r2_width_match: assert property (@(posedge clk) disable iff (!rst_q_n)
    src_code[WIDE_POS] == dst_code[WIDE_POS]);

  a_r3_acc_forced: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ld_first && acc_form) |=>
      (src_code[IDX_W-1:0] == '0 && !src_code[CLASS_POS] && src_code == dst_code));

  a_r8_second_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ld_first && acc_form) ##1 (ld_second && !ld_first) |=>
      ($stable(src_code) && $stable(dst_code)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(ld_first || ld_second) |=> ($stable(src_code) && $stable(dst_code)));

  a_r10_first_wins: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ld_first && ld_second && use_opreg && !acc_form) |=>
      (src_code == dst_code && !src_code[CLASS_POS]));
endmodule

bind operand_selector operand_selector_chk u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .ld_first(ld_first), .ld_second(ld_second),
  .acc_form(acc_form), .use_opreg(use_opreg),
  .src_code(src_code), .dst_code(dst_code)
);

// File: tb/operand_selector_test.sv
`timescale 1ns/1ps
module operand_selector_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_first = 1'b0;
  logic       ld_second = 1'b0;
  logic [7:0] ibyte = 8'h00;
  logic       acc_form = 1'b0;
  logic       use_opreg = 1'b0;
  logic       seg_form = 1'b0;
  logic [4:0] src_code;
  logic [4:0] dst_code;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  operand_selector uut (
    .clk(clk), .rst_n(rst_n), .ld_first(ld_first), .ld_second(ld_second),
    .ibyte(ibyte), .acc_form(acc_form), .use_opreg(use_opreg),
    .seg_form(seg_form), .src_code(src_code), .dst_code(dst_code)
  );

  // kind: 0 mod-reg-r/m, 1 accumulator-immediate, 2 register in opcode, 3 segment move
  // fields: {kind[1:0], first byte, second byte, expected src, expected dst}
  localparam int NV = 11;
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 8'h01, 8'hD8, 5'h0B, 5'h08},
    {2'd0, 8'h03, 8'hD8, 5'h08, 5'h0B},
    {2'd0, 8'h00, 8'hCA, 5'h01, 5'h02},
    {2'd0, 8'h02, 8'hF7, 5'h07, 5'h06},
    {2'd1, 8'h05, 8'hFF, 5'h08, 5'h08},
    {2'd1, 8'h04, 8'hD8, 5'h00, 5'h00},
    {2'd1, 8'h3F, 8'hC1, 5'h08, 5'h08},
    {2'd2, 8'hBE, 8'hD8, 5'h0E, 5'h0E},
    {2'd2, 8'hB3, 8'hFF, 5'h03, 5'h03},
    {2'd3, 8'h8C, 8'hD8, 5'h1B, 5'h08},
    {2'd3, 8'h8E, 8'hD0, 5'h08, 5'h1A}
  };

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic f, input logic s, input logic [1:0] kind, input logic [7:0] b);
    @(negedge clk);
    ld_first  = f;
    ld_second = s;
    ibyte     = b;
    acc_form  = (kind == 2'd1);
    use_opreg = (kind == 2'd2);
    seg_form  = (kind == 2'd3);
    @(negedge clk);
    ld_first  = 1'b0;
    ld_second = 1'b0;
    acc_form  = 1'b0;
    use_opreg = 1'b0;
    seg_form  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    check("R1 src in reset", src_code, 5'h00);
    check("R1 dst in reset", dst_code, 5'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 src after release", src_code, 5'h00);
    check("R1 dst after release", dst_code, 5'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] k;
      k = VEC[i][27:26];
      case (k)
        2'd0: tag = "R5/R6 modrm";
        2'd1: tag = "R3/R8 accumulator";
        2'd2: tag = "R4/R8 opcode register";
        default: tag = "R7/R2 segment";
      endcase
      strobe(1'b1, 1'b0, k, VEC[i][25:18]);
      strobe(1'b0, 1'b1, 2'd0, VEC[i][17:10]);
      check($sformatf("%s vec%0d src", tag, i), src_code, VEC[i][9:5]);
      check($sformatf("%s vec%0d dst", tag, i), dst_code, VEC[i][4:0]);
    end

    // R9: arming strobe alone changes nothing, idle cycles hold
    strobe(1'b1, 1'b0, 2'd0, 8'h03);
    check("R9 src after arming only", src_code, 5'h08);
    check("R9 dst after arming only", dst_code, 5'h1A);
    repeat (5) @(negedge clk);
    check("R9 src idle hold", src_code, 5'h08);
    strobe(1'b0, 1'b1, 2'd0, 8'hCA);
    check("R5/R6 src after armed load", src_code, 5'h0A);
    check("R5/R6 dst after armed load", dst_code, 5'h09);

    // R8: second strobe with nothing pending
    strobe(1'b0, 1'b1, 2'd0, 8'hF7);
    check("R8 src repeated second strobe", src_code, 5'h0A);
    check("R8 dst repeated second strobe", dst_code, 5'h09);

    // R10: both strobes on one edge while a load is pending
    strobe(1'b1, 1'b0, 2'd0, 8'h01);
    strobe(1'b1, 1'b1, 2'd2, 8'hB9);
    check("R10 src first wins", src_code, 5'h09);
    check("R10 dst first wins", dst_code, 5'h09);
    strobe(1'b0, 1'b1, 2'd0, 8'hD8);
    check("R10 src pending cleared", src_code, 5'h09);
    check("R10 dst pending cleared", dst_code, 5'h09);

    // R1: asynchronous reset in mid-run
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check("R1 src async clear", src_code, 5'h00);
    check("R1 dst async clear", dst_code, 5'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    strobe(1'b1, 1'b0, 2'd1, 8'h05);
    check("R3 src after re-reset", src_code, 5'h08);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule